// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers six interrupt sources for a small processor core: four external request pins, the overflow of a timer that runs either 8 or 16 bits wide, and a change detector watching a four-bit input port. For every source it holds a sticky flag, an enable bit and a priority bit. From these it forms two request lines, high and low priority, each gated by its own global enable. It also forms a wake request that ends sleep.

External pins pass through a synchronizer. Each pin then sets its flag on the edge direction chosen by its polarity bit. Pin 0 always requests at high priority. The timer flag is set by whichever overflow pulse the width mode selects. The port detector compares the synchronized nibble with a snapshot that software refreshes by reading the port. Software reaches the block through one write port with four registers: flag clear, enable, priority and control. The flags are visible on an output bus.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all flags, enables and global enables are 0, every priority bit except the fixed one is 0 (low), all edge polarities select falling, and `irq_hi_o`, `irq_lo_o` and `wake_o` are low.
- R2: External pin i (flag bit i, i = 0..3) sets its flag on a rising edge when control bit 3+i is 1, and on a falling edge when it is 0. The opposite edge has no effect. The flag appears on `flags_o` after the third rising clock edge that follows the pin change.
- R3: A flag stays set until a write to register 0 (`wr_sel_i`=0) with a 1 in its bit position. Zeros in that write leave flags unchanged.
- R4: When a clearing write and a new set event hit the same flag on the same clock edge, the flag ends up set.
- R5: Pin 0 always requests at high priority. Bit 0 written to the priority register (`wr_sel_i`=2) has no effect.
- R6: For flags 1 to 5, priority bit = 1 routes the source to `irq_hi_o` and 0 routes it to `irq_lo_o`.
- R7: Flag 4 is set one edge after `tmr_ovf8_i` is high while control bit 2 is 0, or after `tmr_ovf16_i` is high while control bit 2 is 1. The unselected overflow input is ignored.
- R8: Flag 5 is set on every edge at which the synchronized port value differs from the snapshot. A `port_rd_i` pulse loads the synchronized value into the snapshot. A mismatch therefore re-sets the flag after each clear until the read.
- R9: `irq_hi_o` is high exactly when control bit 0 is 1 and some high-priority source has both flag and enable (register 1) set. `irq_lo_o` is the same for low-priority sources with control bit 1.
- R10: `wake_o` is high exactly when `sleep_i` is high and any of flags 0 to 3 has its enable set, whatever the global enables. The timer and port sources never wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 4 | Asynchronous external request pins |
| tmr_ovf8_i | input | 1 | Timer overflow pulse, 8-bit wrap |
| tmr_ovf16_i | input | 1 | Timer overflow pulse, 16-bit wrap |
| port_i | input | 4 | Asynchronous watched port nibble |
| port_rd_i | input | 1 | Port read strobe; refreshes snapshot |
| sleep_i | input | 1 | Core is sleeping |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 flag clear, 1 enable, 2 priority, 3 control |
| wr_data_i | input | 7 | Write data; control: bit0 high global, bit1 low global, bit2 16-bit mode, bits 6:3 pin polarity |
| flags_o | output | 6 | Flags: 3:0 pins, 4 timer, 5 port change |
| irq_hi_o | output | 1 | High-priority request |
| irq_lo_o | output | 1 | Low-priority request |
| wake_o | output | 1 | Wake request |

## Verification
A software clear of a flag and a new hardware set of that same flag can land on one clock edge. The bench provokes this two ways. A pin edge is timed so that its flag-setting edge is the edge that samples a clearing write. A port mismatch is also left pending while its flag is cleared. In both cases the bench expects the flag to survive. A behavioural reference model also meets these collisions under random writes and input activity, and the bench compares against it every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        SEL_FLAG_CLR = 2'd0,
        SEL_ENABLE   = 2'd1,
        SEL_PRIO     = 2'd2,
        SEL_CONTROL  = 2'd3
    } reg_sel_e;

    localparam int CTL_HI_BIT   = 0;
    localparam int CTL_LO_BIT   = 1;
    localparam int CTL_WIDE_BIT = 2;
    localparam int CTL_POL_LSB  = 3;

endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic [W-1:0] rise_sel,
    output logic [W-1:0] hit
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] prev_q, prev_d;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
        prev_d = stg_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
            prev_q <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
            prev_q <= prev_d;
        end
    end

    // per-bit direction choice
    assign hit = (rise_sel & stg_q[STAGES-1] & ~prev_q)
               | (~rise_sel & ~stg_q[STAGES-1] & prev_q);
endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         rd_i,
    output logic         mismatch
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] snap_q, snap_d;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
        snap_d = rd_i ? stg_q[STAGES-1] : snap_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
            snap_q <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
            snap_q <= snap_d;
        end
    end

    assign mismatch = |(stg_q[STAGES-1] ^ snap_q);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter  int EXT_N       = 4,
    parameter  int PORT_W      = 4,
    parameter  int SYNC_STAGES = 2,
    localparam int NS          = EXT_N + 2,
    localparam int WD          = EXT_N + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EXT_N-1:0]  ext_pin_i,
    input  logic              tmr_ovf8_i,
    input  logic              tmr_ovf16_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic              port_rd_i,
    input  logic              sleep_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [WD-1:0]     wr_data_i,
    output logic [NS-1:0]     flags_o,
    output logic              irq_hi_o,
    output logic              irq_lo_o,
    output logic              wake_o
);
    localparam int SRC_TMR  = EXT_N;
    localparam int SRC_PORT = EXT_N + 1;

    typedef struct packed {
        logic [NS-1:0]    flag;
        logic [NS-1:0]    en;
        logic [NS-1:0]    prio;
        logic             glob_hi;
        logic             glob_lo;
        logic             wide;
        logic [EXT_N-1:0] rise;
    } state_t;

    state_t st_q, st_d;

    logic [EXT_N-1:0] ext_hit;
    logic             port_chg;
    logic             tmr_hit;
    logic [NS-1:0]    set_v;
    logic [NS-1:0]    clr_v;
    logic [NS-1:0]    pend;

    irq_sync_edge #(.W(EXT_N), .STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (ext_pin_i),
        .rise_sel (st_q.rise),
        .hit      (ext_hit)
    );

    irq_port_watch #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (port_i),
        .rd_i     (port_rd_i),
        .mismatch (port_chg)
    );

    always_comb begin
        st_d    = st_q;
        tmr_hit = st_q.wide ? tmr_ovf16_i : tmr_ovf8_i;

        set_v           = '0;
        set_v[EXT_N-1:0] = ext_hit;
        set_v[SRC_TMR]  = tmr_hit;
        set_v[SRC_PORT] = port_chg;

        clr_v = '0;
        if (wr_en_i) begin
            case (reg_sel_e'(wr_sel_i))
                SEL_FLAG_CLR: clr_v = wr_data_i[NS-1:0];
                SEL_ENABLE:   st_d.en = wr_data_i[NS-1:0];
                SEL_PRIO:     st_d.prio = {wr_data_i[NS-1:1], 1'b1};
                SEL_CONTROL: begin
                    st_d.glob_hi = wr_data_i[CTL_HI_BIT];
                    st_d.glob_lo = wr_data_i[CTL_LO_BIT];
                    st_d.wide    = wr_data_i[CTL_WIDE_BIT];
                    st_d.rise    = wr_data_i[CTL_POL_LSB +: EXT_N];
                end
                default: ;
            endcase
        end

        // a fresh event outranks a same-edge clear
        st_d.flag = (st_q.flag & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.prio <= NS'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign pend     = st_q.flag & st_q.en;
    assign flags_o  = st_q.flag;
    assign irq_hi_o = st_q.glob_hi & |(pend & st_q.prio);
    assign irq_lo_o = st_q.glob_lo & |(pend & ~st_q.prio);
    assign wake_o   = sleep_i & |pend[EXT_N-1:0];
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter  int EXT_N = 4,
    localparam int NS    = EXT_N + 2,
    localparam int WD    = EXT_N + 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en_i,
    input logic [1:0]    wr_sel_i,
    input logic [WD-1:0] wr_data_i,
    input logic [NS-1:0] flags_o,
    input logic [NS-1:0] en_q,
    input logic          glob_hi,
    input logic          glob_lo,
    input logic          sleep_i,
    input logic          irq_hi_o,
    input logic          irq_lo_o,
    input logic          wake_o
);
    logic [NS-1:0] clr_m;
    logic [NS-1:0] keep_m;
    assign clr_m  = (wr_en_i && wr_sel_i == 2'd0) ? wr_data_i[NS-1:0] : '0;
    assign keep_m = flags_o & ~clr_m;

    // R3
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_o & $past(keep_m)) == $past(keep_m)));

    // R5
    pin0_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[0] && en_q[0] && glob_hi) |-> irq_hi_o);

    // R9
    hi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi_o |-> glob_hi);

    // R9
    lo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo_o |-> glob_lo);

    // R9
    no_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o & en_q) == '0) |-> (!irq_hi_o && !irq_lo_o));

    // R10
    wake_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> sleep_i);

    // R10
    wake_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && |(flags_o[EXT_N-1:0] & en_q[EXT_N-1:0])) |-> wake_o);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.EXT_N(EXT_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .flags_o   (flags_o),
    .en_q      (st_q.en),
    .glob_hi   (st_q.glob_hi),
    .glob_lo   (st_q.glob_lo),
    .sleep_i   (sleep_i),
    .irq_hi_o  (irq_hi_o),
    .irq_lo_o  (irq_lo_o),
    .wake_o    (wake_o)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ext_pin_i = '0;
    logic       tmr_ovf8_i = 1'b0;
    logic       tmr_ovf16_i = 1'b0;
    logic [3:0] port_i = '0;
    logic       port_rd_i = 1'b0;
    logic       sleep_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_sel_i = '0;
    logic [6:0] wr_data_i = '0;
    logic [5:0] flags_o;
    logic       irq_hi_o, irq_lo_o, wake_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_prio_ctrl dut (.*);

    // reference model
    logic [3:0] ph [3];
    logic [3:0] pp [3];
    logic [5:0] m_flag, m_en, m_prio;
    logic       m_ghi, m_glo, m_wide;
    logic [3:0] m_rise, m_snap;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin ph[i] = '0; pp[i] = '0; end
            m_flag = '0; m_en = '0; m_prio = 6'h01;
            m_ghi = 0; m_glo = 0; m_wide = 0; m_rise = '0; m_snap = '0;
        end else begin
            logic [5:0] setv, clrv;
            setv = '0; clrv = '0;
            for (int i = 0; i < 4; i++) begin
                if (m_rise[i]) setv[i] = ph[1][i] && !ph[2][i];
                else           setv[i] = !ph[1][i] && ph[2][i];
            end
            setv[4] = m_wide ? tmr_ovf16_i : tmr_ovf8_i;
            setv[5] = (pp[1] != m_snap);
            if (port_rd_i) m_snap = pp[1];
            if (wr_en_i) begin
                case (wr_sel_i)
                    2'd0: clrv = wr_data_i[5:0];
                    2'd1: m_en = wr_data_i[5:0];
                    2'd2: m_prio = {wr_data_i[5:1], 1'b1};
                    default: begin
                        m_ghi = wr_data_i[0]; m_glo = wr_data_i[1];
                        m_wide = wr_data_i[2]; m_rise = wr_data_i[6:3];
                    end
                endcase
            end
            m_flag = (m_flag & ~clrv) | setv;
            ph[2] = ph[1]; ph[1] = ph[0]; ph[0] = ext_pin_i;
            pp[2] = pp[1]; pp[1] = pp[0]; pp[0] = port_i;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [5:0] pend;
            pend = m_flag & m_en;
            check("R3 model flags", flags_o, m_flag);
            check("R9 model irq_hi", irq_hi_o, int'(m_ghi && |(pend & m_prio)));
            check("R9 model irq_lo", irq_lo_o, int'(m_glo && |(pend & ~m_prio)));
            check("R10 model wake", wake_o, int'(sleep_i && |pend[3:0]));
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] sel, logic [6:0] d);
        wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
        tick(1);
        wr_en_i = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(2);
        #3 rst_n = 1;
        tick(1);
        check("R1 flags", flags_o, 0);
        check("R1 irq_hi", irq_hi_o, 0);
        check("R1 irq_lo", irq_lo_o, 0);
        check("R1 wake", wake_o, 0);

        // R2: polarity
        wr(2'd3, 7'h10);
        ext_pin_i = 4'b0010; tick(3);
        check("R2 pin1 rising", flags_o[1], 1);
        ext_pin_i = 4'b0110; tick(3);
        check("R2 pin2 rising ignored", flags_o[2], 0);
        ext_pin_i = 4'b0010; tick(3);
        check("R2 pin2 falling", flags_o[2], 1);

        // R3: sticky and clear
        tick(4);
        check("R3 still set", flags_o[1], 1);
        wr(2'd0, 7'h00);
        check("R3 zero write", flags_o, 6'h06);
        wr(2'd0, 7'h06);
        check("R3 cleared", flags_o, 0);

        // R4: clear and set on one edge
        ext_pin_i = 4'b1010; tick(3);
        ext_pin_i = 4'b0010; tick(2);
        wr(2'd0, 7'h08);
        check("R4 set wins", flags_o[3], 1);
        wr(2'd0, 7'h08);
        check("R4 later clear", flags_o[3], 0);

        // R5: pin0 fixed high priority
        wr(2'd1, 7'h01); wr(2'd2, 7'h00); wr(2'd3, 7'h11);
        ext_pin_i = 4'b0011; tick(3);
        ext_pin_i = 4'b0010; tick(3);
        check("R5 irq_hi", irq_hi_o, 1);
        wr(2'd3, 7'h13);
        check("R5 irq_lo", irq_lo_o, 0);

        // R9: gating
        wr(2'd3, 7'h12);
        check("R9 hi global off", irq_hi_o, 0);
        wr(2'd1, 7'h00); wr(2'd3, 7'h13);
        check("R9 hi disabled", irq_hi_o, 0);
        check("R9 lo disabled", irq_lo_o, 0);
        wr(2'd0, 7'h01);

        // R6: priority routing
        ext_pin_i = 4'b0000; tick(3);
        ext_pin_i = 4'b0010; tick(3);
        wr(2'd1, 7'h02); wr(2'd2, 7'h00);
        check("R6 low route lo", irq_lo_o, 1);
        check("R6 low route hi", irq_hi_o, 0);
        wr(2'd2, 7'h02);
        check("R6 high route hi", irq_hi_o, 1);
        check("R6 high route lo", irq_lo_o, 0);

        // R10: wake
        sleep_i = 1; wr(2'd3, 7'h10);
        check("R10 wake no global", wake_o, 1);
        check("R10 no irq", irq_hi_o, 0);
        wr(2'd0, 7'h02);
        check("R10 wake cleared", wake_o, 0);
        wr(2'd1, 7'h10);
        tmr_ovf8_i = 1; tick(1); tmr_ovf8_i = 0;
        check("R10 timer flag", flags_o[4], 1);
        check("R10 timer no wake", wake_o, 0);
        sleep_i = 0; wr(2'd0, 7'h10);

        // R7: timer width
        tmr_ovf16_i = 1; tick(1); tmr_ovf16_i = 0;
        check("R7 16 ignored in 8 mode", flags_o[4], 0);
        tmr_ovf8_i = 1; tick(1); tmr_ovf8_i = 0;
        check("R7 8-bit overflow", flags_o[4], 1);
        wr(2'd0, 7'h10); wr(2'd3, 7'h14);
        tmr_ovf8_i = 1; tick(1); tmr_ovf8_i = 0;
        check("R7 8 ignored in 16 mode", flags_o[4], 0);
        tmr_ovf16_i = 1; tick(1); tmr_ovf16_i = 0;
        check("R7 16-bit overflow", flags_o[4], 1);
        wr(2'd0, 7'h10); wr(2'd3, 7'h10);

        // R8: port change
        port_i = 4'h5; tick(3);
        check("R8 change seen", flags_o[5], 1);
        wr(2'd0, 7'h20);
        check("R8 mismatch re-sets", flags_o[5], 1);
        port_rd_i = 1; tick(1); port_rd_i = 0;
        wr(2'd0, 7'h20);
        check("R8 cleared after read", flags_o[5], 0);
        tick(3);
        check("R8 stays clear", flags_o[5], 0);

        // random phase against the model
        for (int c = 0; c < 3000; c++) begin
            ext_pin_i   = ($urandom_range(0, 3) == 0) ? 4'($urandom) : ext_pin_i;
            port_i      = ($urandom_range(0, 15) == 0) ? 4'($urandom) : port_i;
            tmr_ovf8_i  = ($urandom_range(0, 7) == 0);
            tmr_ovf16_i = ($urandom_range(0, 7) == 0);
            port_rd_i   = ($urandom_range(0, 5) == 0);
            sleep_i     = ($urandom_range(0, 3) == 0);
            wr_en_i     = ($urandom_range(0, 3) == 0);
            wr_sel_i    = 2'($urandom);
            wr_data_i   = 7'($urandom);
            tick(1);
        end
        wr_en_i = 0;
        tick(2);
        finish_run();
    end
endmodule